// File: doc/BRIEF.md
# Reset-Anchored Glitch Pulse Sequencer

This block times a single fault-injection pulse against a target reset that it drives itself. A host sends command bytes through an external UART receiver; each byte is presented with a one-cycle valid strobe. Commands load a delay and a pulse width, reset the target on its own, run a full attempt, or start and stop an automatic sweep.

In an attempt the block pulls the active-low target reset down for a fixed number of cycles and then lets it go. It then waits the programmed delay and drives a registered select output high for the programmed width. That output steers an external supply multiplexer onto the glitch rail. Resolution is one clock cycle, and the delay and width carry no jitter. In sweep mode the block repeats attempts by itself. The width climbs from 1 to its maximum, then the delay steps up by one and the width starts again at 1.

Top module: `glitch_sequencer`

## Requirements
- R1: After the synchronous reset, `tgt_rst_n` is 1 and `glitch_sel`, `busy` and `done` are 0.
- R2: Byte 0x04, taken while idle on clock edge E0, starts an attempt. `tgt_rst_n` is 0 from E0 until edge E0+RST_CYC.
- R3: With programmed delay D, `glitch_sel` rises on edge E0+RST_CYC+1+D. A delay of 0 therefore fires on the cycle right after reset release.
- R4: With programmed width W, `glitch_sel` stays high for exactly W cycles. A width of 0 gives no pulse, and the attempt still finishes on edge E0+RST_CYC+1+D.
- R5: `busy` is high from E0 up to the edge that ends the attempt. On that edge `busy` falls and `done` is high for exactly one cycle.
- R6: Byte 0x01 followed by four data bytes loads the 32-bit delay, least significant byte first. Byte 0x02 followed by two data bytes loads the 16-bit width, least significant byte first.
- R7: Byte 0x03 taken while idle gives the same reset pulse as R2 but no glitch. `busy` falls and `done` pulses on the release edge E0+RST_CYC.
- R8: Bytes that arrive while `busy` is high are discarded, with the single exception set out in R10. Opcodes outside 0x01 to 0x05 are ignored.
- R9: Byte 0x05 taken while idle starts a sweep with width 1 and the loaded delay. Each later attempt starts two cycles after the `done` of the previous attempt. Each step adds 1 to the width, and after width WID_MAX the width returns to 1 and the delay rises by 1.
- R10: Byte 0x05 taken while a sweep attempt is running stops the sweep. The running attempt completes and no further attempt starts.
- R11: `glitch_sel` is 0 whenever `tgt_rst_n` is 0 and whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Command or data byte from the UART receiver |
| rx_valid | input | 1 | One-cycle strobe, high when `rx_data` holds a byte |
| tgt_rst_n | output | 1 | Active-low reset driven to the target |
| glitch_sel | output | 1 | Select of the external supply multiplexer, 1 = glitch rail |
| busy | output | 1 | High while an attempt is in progress |
| done | output | 1 | One-cycle strobe at the end of each attempt |

## Verification
Every output is a register, so all timing is counted from E0, the edge that takes the starting byte. The reset falls on E0, is released on E0+RST_CYC, the pulse starts on E0+RST_CYC+1+D, and `done` comes on E0+RST_CYC+1+D+W. The bench drives bytes on falling edges and samples the outputs on falling edges. It indexes each sample k by the number of rising edges since E0, and compares it against values computed from D, W and RST_CYC. For sweep runs the bench measures the delay and width of each pulse from the release of `tgt_rst_n`, so the two-cycle gap between attempts does not affect those checks.

// File: rtl/glitch_seq_pkg.sv
package glitch_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PULSE = 2'd3
  } seq_state_t;

  localparam logic [7:0] OP_SET_DELAY = 8'h01;
  localparam logic [7:0] OP_SET_WIDTH = 8'h02;
  localparam logic [7:0] OP_RESET     = 8'h03;
  localparam logic [7:0] OP_ATTEMPT   = 8'h04;
  localparam logic [7:0] OP_SWEEP     = 8'h05;
endpackage

// File: rtl/glitch_cmd.sv
module glitch_cmd
  import glitch_seq_pkg::*;
#(
  parameter int DLY_W = 32,
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             busy,
  output logic             go_reset,
  output logic             go_attempt,
  output logic             sweep_tog,
  output logic             wr_delay,
  output logic             wr_width,
  output logic [DLY_W-1:0] wr_val,
  output logic             cmd_idle
);
  localparam int DLY_BYTES = DLY_W / 8;
  localparam int WID_BYTES = WID_W / 8;

  logic [2:0]       remain;
  logic             tgt_width;
  logic [DLY_W-9:0] shreg;
  logic             take;

  assign take       = rx_valid && !busy;
  assign cmd_idle   = (remain == 3'd0);
  assign wr_val     = {rx_data, shreg};
  assign go_reset   = take && cmd_idle && (rx_data == OP_RESET);
  assign go_attempt = take && cmd_idle && (rx_data == OP_ATTEMPT);
  // busy is filtered downstream: only a stop is honoured while busy
  assign sweep_tog  = rx_valid && cmd_idle && (rx_data == OP_SWEEP);
  assign wr_delay   = take && (remain == 3'd1) && !tgt_width;
  assign wr_width   = take && (remain == 3'd1) && tgt_width;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      tgt_width <= 1'b0;
      shreg     <= '0;
    end else if (take) begin
      if (cmd_idle) begin
        if (rx_data == OP_SET_DELAY) begin
          remain    <= 3'(DLY_BYTES);
          tgt_width <= 1'b0;
        end else if (rx_data == OP_SET_WIDTH) begin
          remain    <= 3'(WID_BYTES);
          tgt_width <= 1'b1;
        end
      end else begin
        remain <= remain - 3'd1;
        shreg  <= wr_val[DLY_W-1:8];
      end
    end
  end
endmodule

// File: rtl/glitch_cfg.sv
module glitch_cfg #(
  parameter int DLY_W   = 32,
  parameter int WID_W   = 16,
  parameter int WID_MAX = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_delay,
  input  logic             wr_width,
  input  logic [DLY_W-1:0] wr_val,
  input  logic             sweep_tog,
  input  logic             busy,
  input  logic             done,
  input  logic             cmd_idle,
  input  logic             rx_valid,
  output logic [DLY_W-1:0] cfg_delay,
  output logic [WID_W-1:0] cfg_width,
  output logic             sweep_go
);
  localparam logic [WID_W-1:0] W_TOP = WID_W'(WID_MAX);
  localparam logic [WID_W-1:0] W_ONE = WID_W'(1);

  logic sweep_on;

  assign sweep_go = sweep_on && !busy && !done && cmd_idle && !rx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_delay <= '0;
      cfg_width <= W_ONE;
      sweep_on  <= 1'b0;
    end else begin
      if (wr_delay) cfg_delay <= wr_val;
      if (wr_width) cfg_width <= wr_val[DLY_W-1 -: WID_W];
      if (sweep_tog) begin
        if (sweep_on) begin
          sweep_on <= 1'b0;
        end else if (!busy) begin
          sweep_on  <= 1'b1;
          cfg_width <= W_ONE;
        end
      end else if (done && sweep_on) begin
        if (cfg_width >= W_TOP) begin
          cfg_width <= W_ONE;
          cfg_delay <= cfg_delay + 1'b1;
        end else begin
          cfg_width <= cfg_width + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/glitch_engine.sv
module glitch_engine
  import glitch_seq_pkg::*;
#(
  parameter int DLY_W   = 32,
  parameter int WID_W   = 16,
  parameter int RST_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             with_glitch,
  input  logic [DLY_W-1:0] delay,
  input  logic [WID_W-1:0] width,
  output logic             tgt_rst_n,
  output logic             glitch_sel,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             run_glitch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      run_glitch <= 1'b0;
      tgt_rst_n  <= 1'b1;
      glitch_sel <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          glitch_sel <= 1'b0;
          if (start) begin
            state      <= ST_RESET;
            cnt        <= CNT_W'(RST_CYC - 1);
            run_glitch <= with_glitch;
            tgt_rst_n  <= 1'b0;
            busy       <= 1'b1;
          end
        end
        ST_RESET: begin
          if (cnt == '0) begin
            tgt_rst_n <= 1'b1;
            if (run_glitch) begin
              state <= ST_WAIT;
              cnt   <= CNT_W'(delay);
            end else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            if (width == '0) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              state      <= ST_PULSE;
              glitch_sel <= 1'b1;
              cnt        <= CNT_W'(width) - CNT_W'(1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            state      <= ST_IDLE;
            glitch_sel <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/glitch_sequencer.sv
module glitch_sequencer #(
  parameter int DLY_W   = 32,
  parameter int WID_W   = 16,
  parameter int RST_CYC = 1024,
  parameter int WID_MAX = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       tgt_rst_n,
  output logic       glitch_sel,
  output logic       busy,
  output logic       done
);
  logic             go_reset, go_attempt, sweep_tog, sweep_go;
  logic             wr_delay, wr_width, cmd_idle;
  logic [DLY_W-1:0] wr_val, cfg_delay;
  logic [WID_W-1:0] cfg_width;

  glitch_cmd #(.DLY_W(DLY_W), .WID_W(WID_W)) u_cmd (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .go_reset(go_reset), .go_attempt(go_attempt), .sweep_tog(sweep_tog),
    .wr_delay(wr_delay), .wr_width(wr_width), .wr_val(wr_val), .cmd_idle(cmd_idle)
  );

  glitch_cfg #(.DLY_W(DLY_W), .WID_W(WID_W), .WID_MAX(WID_MAX)) u_cfg (
    .clk(clk), .rst(rst), .wr_delay(wr_delay), .wr_width(wr_width), .wr_val(wr_val),
    .sweep_tog(sweep_tog), .busy(busy), .done(done), .cmd_idle(cmd_idle),
    .rx_valid(rx_valid), .cfg_delay(cfg_delay), .cfg_width(cfg_width),
    .sweep_go(sweep_go)
  );

  glitch_engine #(.DLY_W(DLY_W), .WID_W(WID_W), .RST_CYC(RST_CYC)) u_eng (
    .clk(clk), .rst(rst), .start(go_reset || go_attempt || sweep_go),
    .with_glitch(!go_reset), .delay(cfg_delay), .width(cfg_width),
    .tgt_rst_n(tgt_rst_n), .glitch_sel(glitch_sel), .busy(busy), .done(done)
  );
endmodule

// File: rtl/glitch_sequencer_chk.sv
module glitch_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic tgt_rst_n,
  input logic glitch_sel,
  input logic busy,
  input logic done
);
  // R11
  a_r11_glitch_needs_busy: assert property (@(posedge clk) disable iff (rst)
    glitch_sel |-> busy);
  // R11
  a_r11_glitch_off_in_reset: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n |-> !glitch_sel);
  // R5
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  // R2
  a_r2_reset_while_busy: assert property (@(posedge clk) disable iff (rst)
    !tgt_rst_n |-> busy);
endmodule

bind glitch_sequencer glitch_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .tgt_rst_n(tgt_rst_n), .glitch_sel(glitch_sel),
  .busy(busy), .done(done)
);

// File: tb/tb_glitch_sequencer.sv
module tb_glitch_sequencer;
  localparam int NRST = 16;
  localparam int WMAX = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       tgt_rst_n, glitch_sel, busy, done;
  int         total = 0;
  int         bad = 0;

  always #2 clk = ~clk;

  glitch_sequencer #(.RST_CYC(NRST), .WID_MAX(WMAX)) dut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .tgt_rst_n(tgt_rst_n), .glitch_sel(glitch_sel), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // sample index k counts rising edges since the accepting edge
  function automatic int end_edge(input int d, input int w, input bit ronly);
    return ronly ? NRST : NRST + 1 + d + w;
  endfunction
  function automatic bit exp_rstn(input int k);
    return !(k < NRST);
  endfunction
  function automatic bit exp_glitch(input int k, input int d, input int w, input bit ronly);
    return !ronly && (k >= NRST + 1 + d) && (k < NRST + 1 + d + w);
  endfunction

  task automatic load_cfg(input int unsigned d, input int unsigned w);
    send_byte(8'h01);          // R6 delay, LSB first
    send_byte(d[7:0]);
    send_byte(d[15:8]);
    send_byte(d[23:16]);
    send_byte(d[31:24]);
    send_byte(8'h02);          // R6 width, LSB first
    send_byte(w[7:0]);
    send_byte(w[15:8]);
  endtask

  task automatic run_attempt(input int d, input int w, input bit ronly, input string tag);
    int e;
    int m_rst = 0, m_gl = 0, m_busy = 0, m_done = 0;
    e = end_edge(d, w, ronly);
    send_byte(ronly ? 8'h03 : 8'h04);
    for (int k = 0; k <= e + 3; k++) begin
      if (tgt_rst_n !== exp_rstn(k)) m_rst++;
      if (glitch_sel !== exp_glitch(k, d, w, ronly)) m_gl++;
      if (busy !== (k < e)) m_busy++;
      if (done !== (k == e)) m_done++;
      @(negedge clk);
    end
    check(m_rst == 0, {"R2 reset window ", tag}, m_rst, 0);
    check(m_gl == 0, {"R3 R4 R11 pulse timing ", tag}, m_gl, 0);
    check(m_busy == 0, {"R5 busy span ", tag}, m_busy, 0);
    check(m_done == 0, {"R5 done strobe ", tag}, m_done, 0);
  endtask

  task automatic measure(output int d, output int w);
    int steps = 0;
    while (tgt_rst_n !== 1'b0) @(negedge clk);
    while (tgt_rst_n !== 1'b1) @(negedge clk);
    while (glitch_sel !== 1'b1) begin @(negedge clk); steps++; end
    w = 0;
    while (glitch_sel === 1'b1) begin @(negedge clk); w++; end
    d = steps - 1;
    while (busy === 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int md, mw, cnt;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tgt_rst_n === 1'b1 && glitch_sel === 1'b0 && busy === 1'b0 && done === 1'b0,
          "R1 reset state", {tgt_rst_n, glitch_sel, busy, done}, 4'b1000);

    // directed corners
    load_cfg(0, 1);  run_attempt(0, 1, 0, "R3 delay0 width1");
    load_cfg(0, 0);  run_attempt(0, 0, 0, "R4 width0 delay0");
    load_cfg(3, 0);  run_attempt(3, 0, 0, "R4 width0 delay3");
    run_attempt(0, 0, 1, "R7 reset only");
    load_cfg(32'h0000_0105, 32'h0000_0102);
    run_attempt(261, 258, 0, "R6 multi-byte fields");

    // constrained random
    for (int i = 0; i < 8; i++) begin
      int unsigned rd, rw;
      rd = $urandom_range(0, 40);
      rw = $urandom_range(0, 12);
      load_cfg(rd, rw);
      run_attempt(int'(rd), int'(rw), 0, "random");
    end

    // R8: bytes while busy are dropped, unknown opcode ignored
    load_cfg(5, 3);
    send_byte(8'h04);
    send_byte(8'h02);
    send_byte(8'h09);
    send_byte(8'h00);
    while (busy === 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    send_byte(8'h07);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (busy !== 1'b0 || tgt_rst_n !== 1'b1) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R8 unknown opcode ignored", cnt, 0);
    run_attempt(5, 3, 0, "R8 width kept after busy write");

    // R9 sweep from delay 2
    load_cfg(2, 9);
    send_byte(8'h05);
    for (int a = 0; a < 6; a++) begin
      int ed, ew;
      ed = 2 + a / WMAX;
      ew = 1 + a % WMAX;
      measure(md, mw);
      check(md == ed, "R9 sweep delay", md, ed);
      check(mw == ew, "R9 sweep width", mw, ew);
    end
    // R10: stop during a running sweep attempt
    while (busy !== 1'b1) @(negedge clk);
    send_byte(8'h05);
    while (busy === 1'b1) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      if (busy !== 1'b0 || tgt_rst_n !== 1'b1 || glitch_sel !== 1'b0) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R10 sweep stopped", cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule